// File: doc/BRIEF.md
# Branch Target Prediction Cache

This block sits next to the instruction fetch address generator and predicts changes of flow before the branch instructions reach execution. Each fetch address presented on the lookup port is checked against a small direct-mapped, virtually addressed table in the same cycle. If a valid entry matches and its history says "taken", the block asserts a redirect and offers the stored target as the next fetch address. Otherwise the next fetch address is the sequential one, four bytes on.

The execute stage reports each resolved branch on a resolve port, together with the prediction that fetch acted on. The block steps that branch's five-state history, allocates an entry for a taken branch that had none, retires an entry whose history reaches the strongest not-taken state, and raises a one-cycle cancel, with the corrected fetch address, whenever the outcome and the prediction differ. Because the table is virtually mapped, two clear inputs empty it at once: one driven by a control-register write on a context switch, and one driven by any instruction-cache invalidate or push-and-invalidate.

Both data ports carry a valid qualifier and have no ready: the block accepts a lookup and a resolve in every cycle, so neither port ever applies back-pressure. The lookup answer is combinational in the cycle of the request; table updates and the cancel appear one clock later.

Top module: `branch_target_cache`

## Requirements
- R1: After reset every entry is invalid: no lookup hits, `redirect` and `cancel` are low, and `next_pc` equals `fetch_addr + 4`.
- R2: A lookup with no valid entry whose index (address bits [5:2]) and tag (address bits [31:6]) both match gives `lk_hit` low, `redirect` low and `next_pc = fetch_addr + 4`.
- R3: A lookup that hits an entry predicting taken drives `lk_hit` and `redirect` high and `next_pc` to the stored target; a hit predicting not-taken drives `lk_hit` high, `redirect` low and the sequential address.
- R4: Each entry holds a five-state history encoded 0 strongly-not-taken, 1 weakly-not-taken, 2 neutral, 3 weakly-taken, 4 strongly-taken; states 3 and 4 predict taken. A resolved taken outcome moves one step up, a not-taken outcome one step down, saturating at 4 and at 0.
- R5: A resolved taken branch that misses allocates its entry (tag, target) in state 3, replacing whatever held that index; a resolved not-taken branch that misses changes nothing.
- R6: A resolved not-taken outcome that steps a hit entry to state 0 invalidates that entry.
- R7: One cycle after a resolve whose outcome differs from the reported prediction, `cancel` is high for one cycle and `fix_pc` holds the target if taken, or the branch address plus 4 if not taken; otherwise `cancel` stays low.
- R8: A cycle with `clr_sw` high leaves every entry invalid from the next cycle on.
- R9: A cycle with `clr_ic` high has the same whole-table effect as `clr_sw`.
- R10: In a cycle where either clear input is high, lookups report a miss and a resolve makes no table change (the clear wins).
- R11: A resolved taken outcome on a hit entry replaces its stored target with the resolved target.
- R12: With `fetch_valid` low, `lk_hit` and `redirect` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Lookup request qualifier |
| fetch_addr | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | A valid matching entry exists |
| redirect | output | 1 | Hit predicts taken; fetch should jump |
| next_pc | output | 32 | Predicted next fetch address |
| rs_valid | input | 1 | Resolve report qualifier |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome |
| rs_target | input | 32 | Actual target address |
| rs_pred_taken | input | 1 | Prediction fetch acted on for this branch |
| cancel | output | 1 | One-cycle mispredict pulse |
| fix_pc | output | 32 | Corrected fetch address with `cancel` |
| clr_sw | input | 1 | Whole-table clear from control-register write |
| clr_ic | input | 1 | Whole-table clear from instruction-cache invalidate |

## Verification
On every cycle the assertions check that a taken-predicting hit steers `next_pc` to the target, that a clear cycle never reports a hit and empties the table on the next edge, that every stored history stays in range with no valid entry resting at state 0, that a taken miss leaves a valid entry behind, and that a disagreeing resolve yields a cancel. The exact walk through the five history states, saturation at both ends, replacement on aliasing, target refresh and the corrected fetch address can only be shown by the bench's scenarios, which drive sequences of resolves and then read the prediction back through lookups.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic [2:0] {
    H_SNT = 3'd0,
    H_WNT = 3'd1,
    H_NEU = 3'd2,
    H_WT  = 3'd3,
    H_ST  = 3'd4
  } hist_e;

  function automatic logic hist_predicts(input hist_e h);
    return (h == H_WT) || (h == H_ST);
  endfunction
endpackage

// File: rtl/btc_hist_step.sv
module btc_hist_step
  import btc_pkg::*;
(
  input  hist_e cur,
  input  logic  taken,
  output hist_e nxt
);
  always_comb begin
    nxt = cur;
    if (taken) begin
      unique case (cur)
        H_SNT:   nxt = H_WNT;
        H_WNT:   nxt = H_NEU;
        H_NEU:   nxt = H_WT;
        default: nxt = H_ST;
      endcase
    end else begin
      unique case (cur)
        H_ST:    nxt = H_WT;
        H_WT:    nxt = H_NEU;
        H_NEU:   nxt = H_WNT;
        default: nxt = H_SNT;
      endcase
    end
  end
endmodule

// File: rtl/btc_entry.sv
module btc_entry
  import btc_pkg::*;
#(
  parameter int TAG_W  = 26,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  hist_e             wr_hist,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [ADDR_W-1:0] tgt,
  output hist_e             hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      tgt   <= '0;
      hist  <= H_SNT;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (we) begin
      valid <= wr_valid;
      tag   <= wr_tag;
      tgt   <= wr_tgt;
      hist  <= wr_hist;
    end
  end

  // R4: stored history never leaves the five legal codes
  a_r4_hist_range: assert property (@(posedge clk) disable iff (!rst_n)
    hist <= H_ST);

  // R6: a valid entry never rests in the strongest not-taken state
  a_r6_no_valid_snt: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (hist != H_SNT));
endmodule

// File: rtl/btc_array.sv
module btc_array
  import btc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  hist_e             wr_hist,
  input  logic [IDX_W-1:0]  fa_idx,
  output logic              fa_valid,
  output logic [TAG_W-1:0]  fa_tag,
  output logic [ADDR_W-1:0] fa_tgt,
  output hist_e             fa_hist,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ADDR_W-1:0] ra_tgt,
  output hist_e             ra_hist,
  output logic [ENTRIES-1:0] valid_vec
);
  logic              e_valid [ENTRIES];
  logic [TAG_W-1:0]  e_tag   [ENTRIES];
  logic [ADDR_W-1:0] e_tgt   [ENTRIES];
  hist_e             e_hist  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = we && (wr_idx == IDX_W'(g));
    btc_entry #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .we      (sel),
      .wr_valid(wr_valid),
      .wr_tag  (wr_tag),
      .wr_tgt  (wr_tgt),
      .wr_hist (wr_hist),
      .valid   (e_valid[g]),
      .tag     (e_tag[g]),
      .tgt     (e_tgt[g]),
      .hist    (e_hist[g])
    );
    assign valid_vec[g] = e_valid[g];
  end

  assign fa_valid = e_valid[fa_idx];
  assign fa_tag   = e_tag[fa_idx];
  assign fa_tgt   = e_tgt[fa_idx];
  assign fa_hist  = e_hist[fa_idx];
  assign ra_valid = e_valid[ra_idx];
  assign ra_tag   = e_tag[ra_idx];
  assign ra_tgt   = e_tgt[ra_idx];
  assign ra_hist  = e_hist[ra_idx];

  // R8/R9: a clear cycle empties the whole table at the next edge
  a_r8_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_vec == '0));
endmodule

// File: rtl/btc_match.sv
module btc_match #(
  parameter int TAG_W = 26
) (
  input  logic             req,
  input  logic             blocked,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0] addr_tag,
  output logic             hit
);
  assign hit = req && !blocked && ent_valid && (ent_tag == addr_tag);
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
  import btc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_LO  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              lk_hit,
  output logic              redirect,
  output logic [ADDR_W-1:0] next_pc,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic              rs_pred_taken,
  output logic              cancel,
  output logic [ADDR_W-1:0] fix_pc,
  input  logic              clr_sw,
  input  logic              clr_ic
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_LO - IDX_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic clr_any;
  assign clr_any = clr_sw || clr_ic;

  logic [IDX_W-1:0] f_idx, r_idx;
  logic [TAG_W-1:0] f_tag, r_tag;
  assign f_idx = fetch_addr[IDX_LO +: IDX_W];
  assign f_tag = fetch_addr[ADDR_W-1 -: TAG_W];
  assign r_idx = rs_pc[IDX_LO +: IDX_W];
  assign r_tag = rs_pc[ADDR_W-1 -: TAG_W];

  logic              fa_valid, ra_valid;
  logic [TAG_W-1:0]  fa_tag, ra_tag;
  logic [ADDR_W-1:0] fa_tgt, ra_tgt;
  hist_e             fa_hist, ra_hist;
  logic [ENTRIES-1:0] valid_vec;

  logic              we, wr_valid;
  logic [ADDR_W-1:0] wr_tgt;
  hist_e             wr_hist;

  btc_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_any),
    .we       (we),
    .wr_idx   (r_idx),
    .wr_valid (wr_valid),
    .wr_tag   (r_tag),
    .wr_tgt   (wr_tgt),
    .wr_hist  (wr_hist),
    .fa_idx   (f_idx),
    .fa_valid (fa_valid),
    .fa_tag   (fa_tag),
    .fa_tgt   (fa_tgt),
    .fa_hist  (fa_hist),
    .ra_idx   (r_idx),
    .ra_valid (ra_valid),
    .ra_tag   (ra_tag),
    .ra_tgt   (ra_tgt),
    .ra_hist  (ra_hist),
    .valid_vec(valid_vec)
  );

  // Fetch-side lookup
  logic f_hit;
  btc_match #(.TAG_W(TAG_W)) u_fmatch (
    .req      (fetch_valid),
    .blocked  (clr_any),
    .ent_valid(fa_valid),
    .ent_tag  (fa_tag),
    .addr_tag (f_tag),
    .hit      (f_hit)
  );

  assign lk_hit   = f_hit;
  assign redirect = f_hit && hist_predicts(fa_hist);
  assign next_pc  = redirect ? fa_tgt : (fetch_addr + STEP);

  // Resolve-side lookup and history update
  logic r_hit;
  btc_match #(.TAG_W(TAG_W)) u_rmatch (
    .req      (rs_valid),
    .blocked  (clr_any),
    .ent_valid(ra_valid),
    .ent_tag  (ra_tag),
    .addr_tag (r_tag),
    .hit      (r_hit)
  );

  hist_e stepped;
  btc_hist_step u_step (
    .cur  (ra_hist),
    .taken(rs_taken),
    .nxt  (stepped)
  );

  always_comb begin
    we       = 1'b0;
    wr_valid = 1'b0;
    wr_tgt   = ra_tgt;
    wr_hist  = stepped;
    if (rs_valid && !clr_any) begin
      if (r_hit) begin
        we       = 1'b1;
        wr_valid = (stepped != H_SNT);
        wr_hist  = stepped;
        wr_tgt   = rs_taken ? rs_target : ra_tgt;
      end else if (rs_taken) begin
        we       = 1'b1;
        wr_valid = 1'b1;
        wr_hist  = H_WT;
        wr_tgt   = rs_target;
      end
    end
  end

  // Mispredict cancel and corrected address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cancel <= 1'b0;
      fix_pc <= '0;
    end else begin
      cancel <= rs_valid && (rs_taken != rs_pred_taken);
      if (rs_valid)
        fix_pc <= rs_taken ? rs_target : (rs_pc + STEP);
    end
  end

  // R3: a taken-predicting hit steers fetch to the stored target
  a_r3_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (lk_hit && next_pc == fa_tgt));

  // R10: a clear cycle never reports a hit
  a_r10_clear_miss: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |-> !lk_hit);

  // R12: no request, no hit
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (!lk_hit && !redirect));

  // R5: a taken miss leaves a valid entry at its index
  a_r5_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && !r_hit && !clr_any) |=> valid_vec[$past(r_idx)]);

  // R7: a disagreeing resolve raises cancel on the next cycle
  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && (rs_taken != rs_pred_taken)) |=> cancel);

  // R7: cancel is a single-cycle pulse unless fed again
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> !cancel);
endmodule

// File: tb/tb_branch_target_cache.sv
module tb_branch_target_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        lk_hit, redirect, cancel;
  logic [31:0] next_pc, fix_pc;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic [31:0] rs_target = '0;
  logic        rs_pred_taken = 1'b0;
  logic        clr_sw = 1'b0;
  logic        clr_ic = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  branch_target_cache dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .lk_hit(lk_hit), .redirect(redirect), .next_pc(next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_pred_taken(rs_pred_taken),
    .cancel(cancel), .fix_pc(fix_pc),
    .clr_sw(clr_sw), .clr_ic(clr_ic)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Combinational lookup at the current (negedge) time
  task automatic look(input string req, input logic [31:0] a,
                      input logic eh, input logic er, input logic [31:0] tgt);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    #1;
    check({req, " hit"}, 32'(lk_hit), 32'(eh));
    check({req, " redirect"}, 32'(redirect), 32'(er));
    check({req, " next_pc"}, next_pc, er ? tgt : a + 32'd4);
    fetch_valid = 1'b0;
  endtask

  // One resolve cycle; returns at the following negedge
  task automatic resolve(input logic [31:0] pc, input logic tk,
                         input logic [31:0] tgt, input logic pred);
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = tk; rs_target = tgt; rs_pred_taken = pred;
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  task automatic t_reset;
    look("R1", 32'h0000_1008, 1'b0, 1'b0, '0);
    check("R1 cancel", 32'(cancel), 32'd0);
  endtask

  task automatic t_miss;
    look("R2", 32'h0000_7F3C, 1'b0, 1'b0, '0);
    // R5: not-taken miss allocates nothing
    resolve(32'h0000_1104, 1'b0, 32'h0, 1'b0);
    look("R5 nt-miss", 32'h0000_1104, 1'b0, 1'b0, '0);
  endtask

  task automatic t_history_walk;
    logic [31:0] pc = 32'h0000_100C;
    logic [31:0] tg = 32'h0000_4000;
    resolve(pc, 1'b1, tg, 1'b0);            // allocate in state 3
    look("R5 alloc", pc, 1'b1, 1'b1, tg);
    look("R3 taken", pc, 1'b1, 1'b1, tg);
    resolve(pc, 1'b0, tg, 1'b1);            // 3 -> 2
    look("R4 3to2", pc, 1'b1, 1'b0, tg);
    resolve(pc, 1'b0, tg, 1'b0);            // 2 -> 1
    look("R4 2to1", pc, 1'b1, 1'b0, tg);
    resolve(pc, 1'b1, tg, 1'b0);            // 1 -> 2
    look("R4 1to2", pc, 1'b1, 1'b0, tg);
    resolve(pc, 1'b1, tg, 1'b0);            // 2 -> 3
    look("R4 2to3", pc, 1'b1, 1'b1, tg);
    resolve(pc, 1'b1, tg, 1'b1);            // 3 -> 4
    resolve(pc, 1'b1, tg, 1'b1);            // 4 stays 4
    resolve(pc, 1'b0, tg, 1'b1);            // 4 -> 3
    look("R4 sat-high", pc, 1'b1, 1'b1, tg);
    resolve(pc, 1'b0, tg, 1'b1);            // 3 -> 2
    look("R3 hit-nt", pc, 1'b1, 1'b0, tg);
  endtask

  task automatic t_invalidate;
    logic [31:0] pc = 32'h0000_100C;        // entry left in state 2
    resolve(pc, 1'b0, '0, 1'b0);            // 2 -> 1
    look("R6 still", pc, 1'b1, 1'b0, '0);
    resolve(pc, 1'b0, '0, 1'b0);            // 1 -> 0 invalidates
    look("R6 gone", pc, 1'b0, 1'b0, '0);
    resolve(pc, 1'b0, '0, 1'b0);            // miss, not taken: no allocate
    look("R6 stays gone", pc, 1'b0, 1'b0, '0);
  endtask

  task automatic t_cancel;
    resolve(32'h0000_2010, 1'b1, 32'h0000_5550, 1'b0);
    check("R7 cancel taken", 32'(cancel), 32'd1);
    check("R7 fix taken", fix_pc, 32'h0000_5550);
    resolve(32'h0000_2020, 1'b0, 32'h0000_6660, 1'b1);
    check("R7 cancel nt", 32'(cancel), 32'd1);
    check("R7 fix nt", fix_pc, 32'h0000_2024);
    resolve(32'h0000_2010, 1'b1, 32'h0000_5550, 1'b1);
    check("R7 agree", 32'(cancel), 32'd0);
    @(negedge clk);
    check("R7 pulse ends", 32'(cancel), 32'd0);
  endtask

  task automatic t_target_update;
    resolve(32'h0000_1008, 1'b1, 32'h0000_3000, 1'b0);
    look("R11 first", 32'h0000_1008, 1'b1, 1'b1, 32'h0000_3000);
    resolve(32'h0000_1008, 1'b1, 32'h0000_3100, 1'b1);
    look("R11 refreshed", 32'h0000_1008, 1'b1, 1'b1, 32'h0000_3100);
  endtask

  task automatic t_alias;
    look("R2 alias miss", 32'h0000_2008, 1'b0, 1'b0, '0);
    resolve(32'h0000_2008, 1'b1, 32'h0000_8800, 1'b0);
    look("R5 replace new", 32'h0000_2008, 1'b1, 1'b1, 32'h0000_8800);
    look("R5 replace old", 32'h0000_1008, 1'b0, 1'b0, '0);
  endtask

  task automatic t_clear(input bit use_ic);
    string tag = use_ic ? "R9" : "R8";
    resolve(32'h0000_1018, 1'b1, 32'h0000_9000, 1'b0);
    look({tag, " before"}, 32'h0000_1018, 1'b1, 1'b1, 32'h0000_9000);
    @(negedge clk);
    if (use_ic) clr_ic = 1'b1; else clr_sw = 1'b1;
    @(negedge clk);
    clr_ic = 1'b0; clr_sw = 1'b0;
    look({tag, " after"}, 32'h0000_1018, 1'b0, 1'b0, '0);
    look({tag, " other"}, 32'h0000_2010, 1'b0, 1'b0, '0);
  endtask

  task automatic t_clear_same_cycle;
    resolve(32'h0000_1020, 1'b1, 32'h0000_A000, 1'b0);
    @(negedge clk);
    clr_sw = 1'b1;
    rs_valid = 1'b1; rs_pc = 32'h0000_1024; rs_taken = 1'b1;
    rs_target = 32'h0000_B000; rs_pred_taken = 1'b1;
    look("R10 same-cycle", 32'h0000_1020, 1'b0, 1'b0, '0);
    @(negedge clk);
    clr_sw = 1'b0; rs_valid = 1'b0;
    look("R10 resolve dropped", 32'h0000_1024, 1'b0, 1'b0, '0);
  endtask

  task automatic t_idle;
    resolve(32'h0000_1030, 1'b1, 32'h0000_C000, 1'b0);
    fetch_addr  = 32'h0000_1030;
    fetch_valid = 1'b0;
    #1;
    check("R12 hit", 32'(lk_hit), 32'd0);
    check("R12 redirect", 32'(redirect), 32'd0);
    look("R12 then hit", 32'h0000_1030, 1'b1, 1'b1, 32'h0000_C000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss();
    t_history_walk();
    t_invalidate();
    t_cancel();
    t_target_update();
    t_alias();
    t_clear(1'b0);
    t_clear(1'b1);
    t_clear_same_cycle();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule